// File: doc/BRIEF.md
# Doubled-Line-Code Packet Framer

This block is the device-side link engine of a peripheral that sits on a console controller port. The host moves one line bit per exchange: on each exchange strobe it drives a line bit to the device and samples the bit the device returns. Each payload bit travels as two line bits, so a clean stream never holds three equal line bits in a row. The framer uses this rule to lock onto the line-bit pairing. It finds a packet's first half by a six-bit sync pattern, skips idle exchanges between the two halves, and hands the assembled 24-bit command to the device logic with a one-cycle strobe.

In the other direction, the framer encodes a 24-bit response word with the same doubled code. It returns that word on the following exchanges. The reply starts a fixed number of exchanges after the first half is recognized. The default lag is one exchange, and a unit on the second port is built with a lag of two. Nothing in the block interprets what the packets mean.

Top module: `lcf_pkt_framer`

## Requirements
- R1: Inside a half, line bits pair up in order. A pair (1,0) carries payload 0, a pair (0,1) carries payload 1, and the payload value equals the second line bit of the pair.
- R2: While hunting, the framer recognizes a first half when the last six line bits are, oldest first, 1,1,0,1,0,0. The leading 1 is a lead-in bit, and the half's 24 line bits start with the next bit. Every first half therefore opens with payload bits 0,0 followed by a pair that starts with line 0.
- R3: Once a half has started, a 1,1,0,1,0,0 run inside its 24 line bits does not restart recognition, and the packet completes normally.
- R4: After the first half, every exchange carrying line 1 is skipped as idle. The first exchange carrying line 0 opens the second half. That half's first pair must be (0,1), which means its first payload bit is 1.
- R5: A pair of two equal line bits inside either half raises code_err_o for exactly one cycle, drops the packet without raising pkt_valid_o, and returns the framer to hunting for a new sync pattern.
- R6: The second half's 24th line bit completes the packet. In the cycle after that exchange, pkt_valid_o is high for exactly one cycle, and pkt_data_o holds the 24 payload bits with the first received bit at bit 23.
- R7: tx_data_i is captured on the exchange that completes first-half recognition. Starting REPLY_LAG exchanges later, the word is returned most significant bit first, as 48 line bits in the code of R1, one line bit per exchange and on every exchange. A new recognition restarts the reply.
- R8: On every exchange that carries no reply line bit, reply_bit_o is 1. This covers the time before any recognition, the lag slots and the time after the 48th reply bit.
- R9: Cycles without xchg_i leave all state untouched, whatever host_bit_i does. No pulse appears on pkt_valid_o or code_err_o in such a cycle.
- R10: After reset, the framer is hunting, pkt_valid_o and code_err_o are 0, and reply_bit_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xchg_i | input | 1 | One-cycle strobe marking a line exchange |
| host_bit_i | input | 1 | Line bit driven by the host, valid with xchg_i |
| tx_data_i | input | 24 | Response word, captured at first-half recognition |
| reply_bit_o | output | 1 | Line bit returned to the host during the current exchange |
| pkt_valid_o | output | 1 | One-cycle strobe for a completed command packet |
| pkt_data_o | output | 24 | Command payload, first received bit at bit 23 |
| code_err_o | output | 1 | One-cycle pulse when a pair breaks the line code |

## Verification
The bench sends three well-formed packets that differ in payload, in idle gap length (none, short and long) and in idle clock cycles between exchanges. One payload embeds the sync pattern inside its first half, which shows whether recognition is properly locked out during a half. Two broken streams probe the line-code check, one with an equal pair in the middle of the first half and one with a second half opening 0,0. Each must give a single error pulse and no packet, and a clean packet afterwards shows that hunting resumes. Two instances with lags of one and two run side by side on the same stream, and every reply bit on every exchange is compared, so an off-by-one in the reply lag or in the bit order shows up at once.

// File: rtl/lcf_pkg.sv
// Shared definitions for the doubled-line-code framer.
// Assumes: sync pattern is stored oldest bit in the MSB.
package lcf_pkg;
    typedef enum logic [1:0] {
        ST_HUNT,
        ST_HALF_A,
        ST_GAP,
        ST_HALF_B
    } rx_state_t;

    localparam int SYNC_LEN = 6;
    localparam logic [SYNC_LEN-1:0] SYNC_PAT = 6'b110100;
endpackage

// File: rtl/lcf_rx_align.sv
// Receive side: hunts for the sync pattern, pairs line bits, checks the
// code, skips idle exchanges between halves and assembles the payload.
// Assumes: one line bit per xchg_i cycle; the first half opens with the
// sync pattern, whose first bit is a lead-in outside the half.
module lcf_rx_align
    import lcf_pkg::*;
#(
    parameter int PAY_BITS = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xchg_i,
    input  logic                line_i,
    output logic                start_o,
    output logic                pkt_valid_o,
    output logic [PAY_BITS-1:0] pkt_data_o,
    output logic                code_err_o
);
    localparam int HALF_LINE = (2 * PAY_BITS) / 2;
    localparam int CNT_W     = $clog2(HALF_LINE);
    localparam int PRE_CNT   = SYNC_LEN - 1;

    rx_state_t            state;
    logic [SYNC_LEN-1:0]  hist;
    logic [CNT_W-1:0]     cnt;
    logic                 held;
    logic [PAY_BITS-1:0]  pay;
    logic [SYNC_LEN-1:0]  hist_nx;
    logic                 second;
    logic                 pair_bad;
    logic                 last;

    // Decode the current exchange: sync match, pair position and code check.
    always_comb begin
        hist_nx  = {hist[SYNC_LEN-2:0], line_i};
        start_o  = xchg_i && (state == ST_HUNT) && (hist_nx == SYNC_PAT);
        second   = cnt[0];
        pair_bad = second && (held == line_i);
        last     = (cnt == CNT_W'(HALF_LINE - 1));
    end

    // Framing state machine and payload accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_HUNT;
            hist        <= '0;
            cnt         <= '0;
            held        <= 1'b0;
            pay         <= '0;
            pkt_valid_o <= 1'b0;
            pkt_data_o  <= '0;
            code_err_o  <= 1'b0;
        end else begin
            pkt_valid_o <= 1'b0;
            code_err_o  <= 1'b0;
            if (xchg_i) begin
                case (state)
                    ST_HUNT: begin
                        hist <= hist_nx;
                        if (start_o) begin
                            state <= ST_HALF_A;
                            cnt   <= CNT_W'(PRE_CNT);
                            held  <= SYNC_PAT[0];
                            pay   <= '0;
                        end
                    end
                    ST_HALF_A, ST_HALF_B: begin
                        cnt <= cnt + 1'b1;
                        if (pair_bad) begin
                            code_err_o <= 1'b1;
                            state      <= ST_HUNT;
                            hist       <= '0;
                        end else if (second) begin
                            pay <= {pay[PAY_BITS-2:0], line_i};
                            if (last && state == ST_HALF_A) begin
                                state <= ST_GAP;
                            end else if (last) begin
                                pkt_valid_o <= 1'b1;
                                pkt_data_o  <= {pay[PAY_BITS-2:0], line_i};
                                state       <= ST_HUNT;
                                hist        <= '0;
                            end
                        end else begin
                            held <= line_i;
                        end
                    end
                    ST_GAP: begin
                        if (!line_i) begin
                            state <= ST_HALF_B;
                            cnt   <= CNT_W'(1);
                            held  <= 1'b0;
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

    // R9: a cycle without an exchange changes no state and emits no pulse.
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !xchg_i |=> ($stable(state) && !pkt_valid_o && !code_err_o));

    // R5: a dropped packet never also completes.
    a_r5_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_valid_o && code_err_o));

    // R6: the packet strobe lasts one cycle.
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_o |=> !pkt_valid_o);

    // R3: no recognition while a half is in flight.
    a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALF_A || state == ST_HALF_B) |-> !start_o);
endmodule

// File: rtl/lcf_tx_serial.sv
// Reply side: captures the response word at first-half recognition,
// waits the configured lag, then sends it MSB first as 48 doubled line bits.
// Assumes: REPLY_LAG >= 1; reply line idles high.
module lcf_tx_serial #(
    parameter int PAY_BITS  = 24,
    parameter int REPLY_LAG = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xchg_i,
    input  logic                start_i,
    input  logic [PAY_BITS-1:0] tx_data_i,
    output logic                reply_o
);
    localparam int LINE_TOT = 2 * PAY_BITS;
    localparam int CNT_W    = $clog2(LINE_TOT);
    localparam int LAG_W    = $clog2(REPLY_LAG + 1);

    logic                active;
    logic [LAG_W-1:0]    lag_left;
    logic                phase;
    logic [CNT_W-1:0]    line_cnt;
    logic [PAY_BITS-1:0] shreg;

    // Present the line bit for the current exchange.
    always_comb begin
        if (active && lag_left == '0) begin
            reply_o = phase ? shreg[PAY_BITS-1] : ~shreg[PAY_BITS-1];
        end else begin
            reply_o = 1'b1;
        end
    end

    // Advance the reply stream once per exchange.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            lag_left <= '0;
            phase    <= 1'b0;
            line_cnt <= '0;
            shreg    <= '0;
        end else if (xchg_i) begin
            if (start_i) begin
                active   <= 1'b1;
                lag_left <= LAG_W'(REPLY_LAG - 1);
                phase    <= 1'b0;
                line_cnt <= '0;
                shreg    <= tx_data_i;
            end else if (active) begin
                if (lag_left != '0) begin
                    lag_left <= lag_left - 1'b1;
                end else begin
                    phase    <= ~phase;
                    line_cnt <= line_cnt + 1'b1;
                    if (phase) begin
                        shreg <= {shreg[PAY_BITS-2:0], 1'b0};
                    end
                    if (line_cnt == CNT_W'(LINE_TOT - 1)) begin
                        active <= 1'b0;
                    end
                end
            end
        end
    end

    // R7: a reply only begins from a recognition.
    a_r7_start_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(start_i));

    // R7: no reply bit is consumed during the lag slots.
    a_r7_lag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (active && lag_left != '0 && xchg_i && !start_i) |=> (line_cnt == $past(line_cnt)));
endmodule

// File: rtl/lcf_pkt_framer.sv
// Top of the doubled-line-code framer: joins the receive aligner and
// the reply serializer around one exchange strobe.
// Assumes: host holds the line at 1 between halves.
module lcf_pkt_framer #(
    parameter int PAY_BITS  = 24,
    parameter int REPLY_LAG = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xchg_i,
    input  logic                host_bit_i,
    input  logic [PAY_BITS-1:0] tx_data_i,
    output logic                reply_bit_o,
    output logic                pkt_valid_o,
    output logic [PAY_BITS-1:0] pkt_data_o,
    output logic                code_err_o
);
    logic start_w;

    lcf_rx_align #(.PAY_BITS(PAY_BITS)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .xchg_i      (xchg_i),
        .line_i      (host_bit_i),
        .start_o     (start_w),
        .pkt_valid_o (pkt_valid_o),
        .pkt_data_o  (pkt_data_o),
        .code_err_o  (code_err_o)
    );

    lcf_tx_serial #(.PAY_BITS(PAY_BITS), .REPLY_LAG(REPLY_LAG)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .xchg_i    (xchg_i),
        .start_i   (start_w),
        .tx_data_i (tx_data_i),
        .reply_o   (reply_bit_o)
    );

    // R8: the line is high whenever the framer has just left reset.
    a_r8_reset_idle: assert property (@(posedge clk)
        !rst_n |=> reply_bit_o);
endmodule

// File: tb/test_lcf_pkt_framer.sv
// Scoreboard bench: driver tasks queue expected packets and reply bits,
// a monitor pops and compares packets as the design produces them.
module test_lcf_pkt_framer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xchg = 1'b0;
    logic        hbit = 1'b1;
    logic [23:0] txd = '0;
    logic        rep1, rep2, val1, val2, err1, err2;
    logic [23:0] dat1, dat2;

    int checks = 0;
    int errors = 0;
    int exp_err = 0;
    int seen_err1 = 0;
    int seen_err2 = 0;
    bit done = 1'b0;
    logic [23:0] exp_pkt[$];
    bit rq1[$];
    bit rq2[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lcf_pkt_framer #(.PAY_BITS(24), .REPLY_LAG(1)) i_lcf_pkt_framer (
        .clk(clk), .rst_n(rst_n), .xchg_i(xchg), .host_bit_i(hbit),
        .tx_data_i(txd), .reply_bit_o(rep1), .pkt_valid_o(val1),
        .pkt_data_o(dat1), .code_err_o(err1));

    lcf_pkt_framer #(.PAY_BITS(24), .REPLY_LAG(2)) i_lcf_pkt_framer_lag2 (
        .clk(clk), .rst_n(rst_n), .xchg_i(xchg), .host_bit_i(hbit),
        .tx_data_i(txd), .reply_bit_o(rep2), .pkt_valid_o(val2),
        .pkt_data_o(dat2), .code_err_o(err2));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One exchange; reply checked against the model queue (R7 data, R8 idle).
    task automatic exch(input logic b, input int idle);
        bit e1, e2, q1, q2;
        @(negedge clk);
        xchg = 1'b1;
        hbit = b;
        #1;
        q1 = rq1.size() != 0;
        q2 = rq2.size() != 0;
        e1 = q1 ? rq1.pop_front() : 1'b1;
        e2 = q2 ? rq2.pop_front() : 1'b1;
        check(rep1 == e1, q1 ? "R7 reply lag1" : "R8 idle lag1", rep1, e1);
        check(rep2 == e2, q2 ? "R7 reply lag2" : "R8 idle lag2", rep2, e2);
        @(posedge clk);
        #1;
        xchg = 1'b0;
        hbit = 1'($urandom);  // R9 garbage while no exchange
        repeat (idle) @(posedge clk);
    endtask

    task automatic fill_reply(input logic [23:0] t);
        rq1.delete();
        rq2.delete();
        rq2.push_back(1'b1);
        for (int k = 23; k >= 0; k--) begin
            rq1.push_back(~t[k]); rq1.push_back(t[k]);
            rq2.push_back(~t[k]); rq2.push_back(t[k]);
        end
    endtask

    function automatic logic line_of(input logic [11:0] h, input int i);
        return (i % 2 == 0) ? ~h[11 - i/2] : h[11 - i/2];
    endfunction

    // Lead-in plus first half; optional corrupted index (-1 for none).
    task automatic send_half_a(input logic [23:0] p, input logic [23:0] t,
                               input int bad, input int idle);
        txd = t;
        exch(1'b1, idle);
        for (int i = 0; i < 24; i++) begin
            if (i == bad) begin
                exch(line_of(p[23:12], i - 1), idle);
                return;
            end
            exch(line_of(p[23:12], i), idle);
            if (i == 4) fill_reply(t);  // R2 recognition exchange
        end
    endtask

    task automatic send_pkt(input logic [23:0] p, input logic [23:0] t,
                            input int gap, input int idle);
        send_half_a(p, t, -1, idle);
        repeat (gap) exch(1'b1, idle);  // R4 idle exchanges skipped
        exp_pkt.push_back(p);
        for (int i = 0; i < 24; i++) exch(line_of(p[11:0], i), idle);
    endtask

    // Monitor: pop expected packets as the design delivers them (R6, R1).
    always @(negedge clk) begin
        if (rst_n) begin
            if (val1) begin
                if (exp_pkt.size() == 0) begin
                    check(1'b0, "R5/R6 unexpected packet", dat1, 0);
                end else begin
                    logic [23:0] e;
                    e = exp_pkt.pop_front();
                    check(dat1 == e, "R6 packet data", dat1, e);
                    check(val2 && dat2 == e, "R6 packet lag2", dat2, e);
                end
            end
            if (err1) seen_err1++;
            if (err2) seen_err2++;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(val1 == 0 && val2 == 0, "R10 valid low", val1, 0);
        check(err1 == 0 && err2 == 0, "R10 err low", err1, 0);
        check(rep1 == 1 && rep2 == 1, "R10 reply high", rep1, 1);
        rst_n = 1'b1;
        repeat (8) exch(1'b1, 0);                        // R8 before any packet
        send_pkt(24'h3A59C3, 24'hC35A96, 3, 0);          // R1 R2 R6 R7
        send_pkt(24'h2F08A1, 24'h0F1E2D, 0, 2);          // R4 zero gap, R9 idle cycles
        send_pkt(24'h29C8F5, 24'h7E8101, 7, 1);          // R3 sync run inside half
        repeat (4) exch(1'b1, 0);
        exp_err++;
        send_half_a(24'h35AF0F, 24'h123456, 9, 0);       // R5 equal pair in first half
        @(negedge clk); #2;
        check(seen_err1 == exp_err && seen_err2 == exp_err, "R5 error pulse half A", seen_err1, exp_err);
        repeat (3) exch(1'b1, 0);
        send_half_a(24'h35AF0F, 24'h654321, -1, 0);
        repeat (2) exch(1'b1, 0);
        exp_err++;
        exch(1'b0, 0);
        exch(1'b0, 0);                                   // R4 second half must open 0,1
        @(negedge clk); #2;
        check(seen_err1 == exp_err && seen_err2 == exp_err, "R4/R5 error pulse half B", seen_err1, exp_err);
        repeat (3) exch(1'b1, 0);
        send_pkt(24'h35AF0F, 24'hFFFF00, 2, 0);          // R5 recovery after error
        repeat (50) exch(1'b1, 0);                       // R7/R8 reply tail then idle
        @(negedge clk); #2;
        check(exp_pkt.size() == 0, "R6 all packets delivered", exp_pkt.size(), 0);
        check(seen_err1 == exp_err, "R5 error count", seen_err1, exp_err);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule